// File: doc/BRIEF.md
# DSP Interrupt Control and Status Register

This block holds one 16-bit control and status word for a DSP subsystem and merges three interrupt causes into one interrupt line toward the host processor. The three causes are the DSP itself, the auxiliary-memory DMA engine and the audio DMA engine. Each cause has a sticky flag and an enable bit. The flag is set by a one-cycle event pulse from the engine that owns it. The host clears a flag by writing a 1 to it. The same word also carries the DSP control bits for reset, assert-interrupt, halt and init, and it reflects a DMA-busy status input.

Software reads and writes the word through a simple 16-bit port. A write takes effect at the next clock edge, and a read is combinational. Each enable bit sits one position above its flag bit. Because of that layout, the interrupt line is the OR of `(word >> 1) & word` over the three flag positions. A write that sets the reset bit also sends the audio DMA engine a one-cycle request to clear its control word.

Top module: `dsp_irq_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x0004 (only the halt bit, bit 2, set, with `dma_busy` low), `irq_out` is low and all control outputs except `dsp_halt` are low.
- R2: A pulse on `audio_dma_evt`, `aux_dma_evt` or `dsp_evt` sets its flag (bit 3, bit 5 or bit 7 respectively) at the next edge. The flag stays set after the pulse ends, until software clears it.
- R3: A write with a 1 in a flag position clears that flag. A write with a 0 in a flag position leaves the flag unchanged.
- R4: A write stores the enable bits (bit 4 for audio DMA, bit 6 for auxiliary DMA, bit 8 for DSP) and the control bits (bit 0 reset, bit 1 assert-interrupt, bit 2 halt, bit 10 init) directly. These bits drive `dsp_reset`, `dsp_assert`, `dsp_halt` and `dsp_init`.
- R5: `irq_out` is high exactly when some flag is set and the enable bit directly above it is also set. A set flag with its enable clear does not raise `irq_out`.
- R6: When an event pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R7: A write with bit 0 set raises `audio_ctl_clr` for exactly one cycle, the cycle after the write.
- R8: Bit 9 always reads the `dma_busy` input, and writes to it are ignored. Bits 11 to 15 read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register contents |
| dsp_evt | input | 1 | DSP interrupt event pulse |
| aux_dma_evt | input | 1 | Auxiliary-memory DMA completion pulse |
| audio_dma_evt | input | 1 | Audio DMA block-start pulse |
| dma_busy | input | 1 | Auxiliary DMA busy status, shown at bit 9 |
| irq_out | output | 1 | Combined interrupt to the processor |
| dsp_reset | output | 1 | DSP reset control bit |
| dsp_assert | output | 1 | DSP assert-interrupt control bit |
| dsp_halt | output | 1 | DSP halt control bit |
| dsp_init | output | 1 | DSP init control bit |
| audio_ctl_clr | output | 1 | One-cycle request to clear the audio DMA control word |

## Verification
Every stored bit appears on `rd_data` in the cycle after it changes, so a corrupted flag or enable shows up on the port one edge after the event or write that caused it. A flag that is set but not enabled is invisible on `irq_out`, so each stimulus step checks both the read-back word and the interrupt line. Those two checks together tell a lost flag apart from a wrong enable pairing. The tests that matter most are a clear and an event colliding on the same edge, a write of all ones into the bits that cannot be written, and the single-cycle width of the clear request.

// File: rtl/dsp_irq_ctrl.sv
module dsp_irq_ctrl #(
  parameter int W        = 16,
  parameter int NSRC     = 3,
  parameter int FLAG_LSB = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         dsp_evt,
  input  logic         aux_dma_evt,
  input  logic         audio_dma_evt,
  input  logic         dma_busy,
  output logic         irq_out,
  output logic         dsp_reset,
  output logic         dsp_assert,
  output logic         dsp_halt,
  output logic         dsp_init,
  output logic         audio_ctl_clr
);
  localparam int BIT_RST  = 0;
  localparam int BIT_AST  = 1;
  localparam int BIT_HALT = 2;
  localparam int BIT_BUSY = FLAG_LSB + 2*NSRC;
  localparam int BIT_INIT = BIT_BUSY + 1;

  logic [NSRC-1:0] flags, masks, evt, wclr;
  logic [W-1:0]    view, flag_sel;
  logic            clr_q;

  assign evt = {dsp_evt, aux_dma_evt, audio_dma_evt};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign wclr[i] = wr_en & wr_data[FLAG_LSB + 2*i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags      <= '0;
      masks      <= '0;
      dsp_reset  <= 1'b0;
      dsp_assert <= 1'b0;
      dsp_halt   <= 1'b1;
      dsp_init   <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      flags <= (flags & ~wclr) | evt;
      clr_q <= wr_en & wr_data[BIT_RST];
      if (wr_en) begin
        for (int i = 0; i < NSRC; i++) masks[i] <= wr_data[FLAG_LSB + 2*i + 1];
        dsp_reset  <= wr_data[BIT_RST];
        dsp_assert <= wr_data[BIT_AST];
        dsp_halt   <= wr_data[BIT_HALT];
        dsp_init   <= wr_data[BIT_INIT];
      end
    end
  end

  always_comb begin
    view           = '0;
    flag_sel       = '0;
    view[BIT_RST]  = dsp_reset;
    view[BIT_AST]  = dsp_assert;
    view[BIT_HALT] = dsp_halt;
    view[BIT_BUSY] = dma_busy;
    view[BIT_INIT] = dsp_init;
    for (int i = 0; i < NSRC; i++) begin
      view[FLAG_LSB + 2*i]     = flags[i];
      view[FLAG_LSB + 2*i + 1] = masks[i];
      flag_sel[FLAG_LSB + 2*i] = 1'b1;
    end
  end

  assign rd_data       = view;
  assign irq_out       = |((view >> 1) & view & flag_sel);
  assign audio_ctl_clr = clr_q;
endmodule

// File: rtl/dsp_irq_ctrl_chk.sv
module dsp_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        audio_dma_evt,
  input logic        dma_busy,
  input logic        irq_out,
  input logic        audio_ctl_clr
);
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rd_data[3]) |=> rd_data[3]); // R2
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    audio_dma_evt |=> rd_data[3]); // R6
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3] && !audio_dma_evt) |=> !rd_data[3]); // R3
  AST_IRQ_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((rd_data[3] && rd_data[4]) || (rd_data[5] && rd_data[6]) || (rd_data[7] && rd_data[8]))); // R5
  AST_CLR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0]) |=> audio_ctl_clr); // R7
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (audio_ctl_clr && !$past(wr_en && wr_data[0])) |-> 1'b0); // R7
  AST_BUSY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[9] == dma_busy); // R8
endmodule

bind dsp_irq_ctrl dsp_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .audio_dma_evt(audio_dma_evt), .dma_busy(dma_busy),
  .irq_out(irq_out), .audio_ctl_clr(audio_ctl_clr)
);

// File: tb/dsp_irq_ctrl_bench.sv
module dsp_irq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic dsp_evt = 0, aux_dma_evt = 0, audio_dma_evt = 0, dma_busy = 0;
  logic [15:0] rd_data;
  logic irq_out, dsp_reset, dsp_assert, dsp_halt, dsp_init, audio_ctl_clr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dsp_irq_ctrl u_dsp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .dsp_evt(dsp_evt), .aux_dma_evt(aux_dma_evt), .audio_dma_evt(audio_dma_evt),
    .dma_busy(dma_busy), .irq_out(irq_out), .dsp_reset(dsp_reset),
    .dsp_assert(dsp_assert), .dsp_halt(dsp_halt), .dsp_init(dsp_init),
    .audio_ctl_clr(audio_ctl_clr)
  );

  // {wr_en, wr_data, evt{dsp,aux,audio}, busy, exp_rd, exp_irq, exp_clr}
  localparam int NV = 12;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 16'h0154, 3'b000, 1'b0, 16'h0154, 1'b0, 1'b0}, // R4 enables + halt
    {1'b0, 16'h0000, 3'b001, 1'b0, 16'h015C, 1'b1, 1'b0}, // R2 R5 audio flag
    {1'b0, 16'h0000, 3'b000, 1'b1, 16'h035C, 1'b1, 1'b0}, // R2 sticky, R8 busy
    {1'b1, 16'h0154, 3'b000, 1'b0, 16'h015C, 1'b1, 1'b0}, // R3 write 0 keeps
    {1'b1, 16'h015C, 3'b000, 1'b0, 16'h0154, 1'b0, 1'b0}, // R3 write 1 clears
    {1'b1, 16'h0044, 3'b000, 1'b0, 16'h0044, 1'b0, 1'b0}, // R4 aux enable only
    {1'b0, 16'h0000, 3'b100, 1'b0, 16'h00C4, 1'b0, 1'b0}, // R5 flag without enable
    {1'b0, 16'h0000, 3'b010, 1'b0, 16'h00E4, 1'b1, 1'b0}, // R5 aux pair
    {1'b1, 16'h00E4, 3'b010, 1'b0, 16'h0064, 1'b1, 1'b0}, // R6 set beats clear
    {1'b1, 16'h0001, 3'b000, 1'b0, 16'h0021, 1'b0, 1'b1}, // R7 reset bit
    {1'b1, 16'hFE22, 3'b000, 1'b0, 16'h0402, 1'b0, 1'b0}, // R8 ro bits, R7 one cycle
    {1'b1, 16'h0000, 3'b000, 1'b0, 16'h0000, 1'b0, 1'b0}  // R4 all clear
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd", rd_data, 16'h0004);
    chk("R1 irq", {15'd0, irq_out}, 16'd0);
    chk("R1 ctl", {12'd0, dsp_reset, dsp_assert, dsp_halt, dsp_init}, 16'h0002);
    chk("R1 clr", {15'd0, audio_ctl_clr}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      wr_en         = VEC[i][38];
      wr_data       = VEC[i][37:22];
      dsp_evt       = VEC[i][21];
      aux_dma_evt   = VEC[i][20];
      audio_dma_evt = VEC[i][19];
      dma_busy      = VEC[i][18];
      @(negedge clk);
      wr_en = 0; dsp_evt = 0; aux_dma_evt = 0; audio_dma_evt = 0;
      chk($sformatf("vec%0d rd", i), rd_data, VEC[i][17:2]);
      chk($sformatf("vec%0d irq", i), {15'd0, irq_out}, {15'd0, VEC[i][1]});
      chk($sformatf("vec%0d clr", i), {15'd0, audio_ctl_clr}, {15'd0, VEC[i][0]});
    end

    // R4 control outputs follow written bits
    wr_en = 1; wr_data = 16'h0407;
    @(negedge clk); wr_en = 0;
    chk("R4 ctl", {12'd0, dsp_reset, dsp_assert, dsp_halt, dsp_init}, 16'h000F);
    @(negedge clk);
    chk("R7 clr drops", {15'd0, audio_ctl_clr}, 16'd0);

    // R6 on DSP flag: set and clear collide
    wr_en = 1; wr_data = 16'h0100;
    @(negedge clk);
    wr_data = 16'h0180; dsp_evt = 1;
    @(negedge clk); wr_en = 0; dsp_evt = 0;
    chk("R6 dsp collide", rd_data, 16'h0180);
    chk("R5 dsp irq", {15'd0, irq_out}, 16'd1);

    // R1 reset mid-run restores default
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 rerst rd", rd_data, 16'h0004);
    chk("R1 rerst irq", {15'd0, irq_out}, 16'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule